// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Front End

This block sits behind a two-wire serial bus and gives a master access to a 256-byte non-volatile store. It samples the open-drain clock and data lines with the system clock and finds bus START and STOP events. It compares each device-address byte with a fixed 4-bit group code plus three strap pins, and acknowledges only its own address. It accepts a word address and then data bytes for writing. For reads it sends bytes from the current word address, and a random read is formed from a dummy write followed by a repeated START.

Write data is held in an eight-entry buffer until STOP. A write-cycle sequencer then copies the buffer into the array and stays busy for a fixed number of system cycles. While it is busy the slave refuses its own address. A mode pin chooses byte-write mode or page-write mode. In byte-write mode the word address counts through all eight bits. In page-write mode only the low three bits count, so writes wrap inside an aligned 8-byte page. The block pulls SDA low only by asserting its `sda_pull` output, and it changes that output only while the synchronised SCL is low.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START aborts any byte in progress and restarts address reception. Bytes clocked without a preceding START get no acknowledge.
- R2: The device-address byte is sent MSB first. Its upper seven bits must equal {4'b1010, strap[2:0]} to be acknowledged, and bit 0 is the direction, 1 for read and 0 for write. Any other address is not acknowledged.
- R3: With page_mode=0, data bytes after the word address are written to consecutive addresses, wrapping modulo 256. The first seven are acknowledged and written. The eighth and later bytes get no acknowledge and are dropped.
- R4: With page_mode=1, up to eight data bytes are acknowledged. Only word-address bits [2:0] increment, and bits [7:3] stay fixed.
- R5: With page_mode=1, a ninth data byte and every later one gets no acknowledge. The whole transfer is then discarded, no byte is written, and busy stays low.
- R6: A read sends the byte at the current word address and then increments the full 8-bit address, wrapping from 255 to 0. Reading continues for as long as the master acknowledges. A current-address read starts where the last access left off.
- R7: A write of only the word address, followed by a repeated START with direction 1, reads from that word address.
- R8: When the master does not acknowledge a read byte, the slave releases SDA and stays silent until the next START. SDA is released after reset.
- R9: After a STOP that ends a write with at least one accepted byte, busy stays high for WR_TICKS cycles. While busy is high the device address is not acknowledged.
- R10: sda_pull changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap | input | 3 | Low bits of the device address |
| page_mode | input | 1 | 1 selects page-write mode, 0 selects byte-write mode |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Write cycle in progress |

## Verification
The assertions assume the master follows bus timing: SDA moves only while SCL is low, except at START and STOP. Each SCL phase also lasts several system clocks, so the synchronisers see every edge. The bench drives SCL with phases of at least four system clocks. It changes its data only in the middle of the low phase, and it samples only in the middle of the high phase. A monitor in the bench watches `sda_pull` during every SCL high phase. page_mode is held constant across each transaction, so the assertions can relate the write count to the mode that is selected.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter logic [3:0] DEV_HI   = 4'b1010,
  parameter int         WR_TICKS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap,
  input  logic       page_mode,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic       busy
);
  localparam int TW = $clog2(WR_TICKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WA, S_WD, S_RD} st_t;

  logic [2:0] scl_sy, sda_sy;
  logic       scl_s, scl_q, sda_s, sda_q;
  logic       scl_rise, scl_fall, start_c, stop_c;
  st_t        st, nxt_st;
  logic [3:0] bitcnt, cnt, lim;
  logic [7:0] shreg, tx, addr, base;
  logic       discard, mack;
  logic [7:0] mem [256];
  logic [7:0] wbuf [8];
  logic [7:0] c_base, waddr;
  logic       c_page, commit, wr_en;
  logic [3:0] c_n, c_i;
  logic [TW-1:0] wtimer;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_in};
      sda_sy <= {sda_sy[1:0], sda_in};
    end

  assign scl_s    = scl_sy[1];
  assign scl_q    = scl_sy[2];
  assign sda_s    = sda_sy[1];
  assign sda_q    = sda_sy[2];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign lim      = page_mode ? 4'd8 : 4'd7;
  assign busy     = wtimer != '0;
  assign commit   = stop_c && st == S_WD && cnt != 4'd0 && !discard;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; nxt_st <= S_IDLE; bitcnt <= '0; cnt <= '0;
      shreg <= '0; tx <= '0; addr <= '0; base <= '0;
      discard <= 1'b0; mack <= 1'b0; sda_pull <= 1'b0;
    end else if (start_c) begin
      st <= S_DEV; bitcnt <= '0; sda_pull <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; bitcnt <= '0; sda_pull <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_WA, S_WD: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
            if (st == S_DEV) begin
              if (shreg[7:1] == {DEV_HI, strap} && !busy) begin
                sda_pull <= 1'b1;
                nxt_st   <= shreg[0] ? S_RD : S_WA;
              end else begin
                sda_pull <= 1'b0;
                nxt_st   <= S_IDLE;
              end
            end else if (st == S_WA) begin
              sda_pull <= 1'b1; addr <= shreg; base <= shreg;
              cnt <= '0; discard <= 1'b0; nxt_st <= S_WD;
            end else begin
              nxt_st <= S_WD;
              if (!discard && cnt < lim) begin
                sda_pull <= 1'b1;
                wbuf[cnt[2:0]] <= shreg;
                cnt  <= cnt + 4'd1;
                addr <= page_mode ? {addr[7:3], addr[2:0] + 3'd1} : addr + 8'd1;
              end else begin
                sda_pull <= 1'b0;
                if (page_mode) discard <= 1'b1;
              end
            end
          end else if (scl_fall && bitcnt == 4'd9) begin
            bitcnt <= '0;
            st     <= nxt_st;
            if (nxt_st == S_RD) begin
              tx <= mem[addr]; sda_pull <= ~mem[addr][7];
            end else
              sda_pull <= 1'b0;
          end
        end
        S_RD: begin
          if (scl_rise && bitcnt < 4'd8) bitcnt <= bitcnt + 4'd1;
          else if (scl_rise && bitcnt == 4'd9) mack <= ~sda_s;
          else if (scl_fall && bitcnt != 4'd0 && bitcnt < 4'd8) begin
            tx <= {tx[6:0], 1'b0}; sda_pull <= ~tx[6];
          end else if (scl_fall && bitcnt == 4'd8) begin
            sda_pull <= 1'b0; bitcnt <= 4'd9; addr <= addr + 8'd1;
          end else if (scl_fall && bitcnt == 4'd9) begin
            if (mack) begin
              bitcnt <= '0; tx <= mem[addr]; sda_pull <= ~mem[addr][7];
            end else
              st <= S_IDLE;
          end
        end
        default: ;
      endcase
    end

  assign wr_en = c_i != c_n;
  assign waddr = c_page ? {c_base[7:3], c_base[2:0] + c_i[2:0]} : c_base + {4'd0, c_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wtimer <= '0; c_i <= '0; c_n <= '0; c_base <= '0; c_page <= 1'b0;
    end else if (commit) begin
      wtimer <= TW'(WR_TICKS); c_i <= '0; c_n <= cnt;
      c_base <= base; c_page <= page_mode;
    end else begin
      if (busy) wtimer <= wtimer - 1'b1;
      if (wr_en) c_i <= c_i + 4'd1;
    end

  always_ff @(posedge clk)
    if (wr_en) mem[waddr] <= wbuf[c_i[2:0]];

  AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !$past(scl_s)); // R10
  AST_NACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEV && scl_fall && bitcnt == 4'd8 && busy) |=> !sda_pull); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_pull); // R8
  AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy); // R9
  AST_BUF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WD) |-> cnt <= 4'd8); // R5
  AST_BYTE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !page_mode |-> cnt <= 4'd7); // R3
endmodule

// File: tb/eeprom_i2c_slave_bench.sv
`timescale 1ns/1ps
module eeprom_i2c_slave_bench;
  localparam int Q = 4;
  localparam int WT = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] strap = 3'b101;
  logic page_mode = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_line, sda_pull, busy;
  logic [7:0] refm [256];
  int checks = 0, errors = 0, viol = 0, salt = 5;
  logic prev_pull = 1'b0;

  assign sda_line = sda_m & ~sda_pull;
  always #4 clk = ~clk;

  eeprom_i2c_slave #(.DEV_HI(4'b1010), .WR_TICKS(WT)) u_eeprom_i2c_slave (
    .clk(clk), .rst_n(rst_n), .strap(strap), .page_mode(page_mode),
    .scl_in(scl), .sda_in(sda_line), .sda_pull(sda_pull), .busy(busy));

  always @(negedge clk) begin
    if (scl && sda_pull !== prev_pull) viol++;
    prev_pull = sda_pull;
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual %0d expected %0d", req, act, exp); end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ak);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); ak = !sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl = 1'b0; tick(Q);
    end
    sda_m = !mack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev(input bit rd);
    return {4'b1010, strap, rd};
  endfunction

  task automatic write_seq(input logic [7:0] a, input int n, input bit pg, input string req);
    bit ak, exp;
    logic [7:0] d [12];
    logic [7:0] wa;
    page_mode = pg;
    bus_start;
    send_byte(dev(0), ak); chk(ak, req, ak, 1);
    send_byte(a, ak);      chk(ak, req, ak, 1);
    for (int i = 0; i < n; i++) begin
      d[i] = a * 8'd13 + 8'(i * 29) + 8'(salt);
      send_byte(d[i], ak);
      exp = pg ? (i < 8) : (i < 7);
      chk(ak == exp, req, ak, exp);
    end
    bus_stop;
    salt += 17;
    if (!pg || n <= 8)
      for (int i = 0; i < n; i++)
        if (pg ? i < 8 : i < 7) begin
          wa = pg ? {a[7:3], a[2:0] + 3'(i)} : a + 8'(i);
          refm[wa] = d[i];
        end
    while (busy) tick(1);
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string req);
    bit ak;
    logic [7:0] b;
    bus_start;
    send_byte(dev(0), ak); chk(ak, req, ak, 1);
    send_byte(a, ak);      chk(ak, req, ak, 1);
    bus_start;
    send_byte(dev(1), ak); chk(ak, req, ak, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i != n - 1);
      chk(b === refm[8'(a + 8'(i))], req, b, refm[8'(a + 8'(i))]);
    end
    bus_stop;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ak;
    logic [7:0] b;
    tick(5); rst_n = 1'b1; tick(5);
    chk(sda_pull == 1'b0, "R8 reset release", sda_pull, 0);
    chk(busy == 1'b0, "R9 reset idle", busy, 0);

    for (int a = 0; a < 256; a += 8) write_seq(8'(a), 8, 1'b1, "R4 page fill");
    rand_read(8'd0, 257, "R6 R7 full sweep with wrap");
    bus_start; send_byte(dev(1), ak); chk(ak, "R6 current read", ak, 1);
    recv_byte(b, 1'b0); chk(b === refm[1], "R6 current read addr", b, refm[1]);
    tick(2); chk(sda_pull == 1'b0, "R8 released after nack", sda_pull, 0);
    bus_stop;

    write_seq(8'd100, 9, 1'b0, "R3 byte limit");
    rand_read(8'd98, 12, "R3 byte readback");
    write_seq(8'd252, 7, 1'b0, "R3 byte wrap");
    rand_read(8'd250, 10, "R3 wrap readback");
    write_seq(8'h2D, 8, 1'b1, "R4 page wrap");
    write_seq(8'h83, 5, 1'b1, "R4 partial page");
    rand_read(8'h28, 8, "R4 page readback");
    rand_read(8'h80, 8, "R4 partial readback");

    write_seq(8'h58, 10, 1'b1, "R5 page overflow");
    chk(busy == 1'b0, "R5 no write cycle", busy, 0);
    rand_read(8'h56, 12, "R5 untouched");

    page_mode = 1'b0;
    bus_start; send_byte(dev(0), ak); send_byte(8'h10, ak); send_byte(8'hA5, ak); bus_stop;
    refm[8'h10] = 8'hA5;
    chk(busy == 1'b1, "R9 busy after write", busy, 1);
    bus_start; send_byte(dev(0), ak); chk(!ak, "R9 nack while busy", ak, 0); bus_stop;
    while (busy) tick(1);
    rand_read(8'h10, 1, "R9 ack after busy");

    for (int d = 0; d < 128; d++) begin
      bus_start; send_byte({7'(d), 1'b0}, ak); bus_stop;
      chk(ak == (d == {4'b1010, strap}), "R2 address sweep", ak, d == {4'b1010, strap});
    end
    strap = 3'b010;
    bus_start; send_byte(8'hA4, ak); chk(ak, "R2 strap 010 match", ak, 1); bus_stop;
    bus_start; send_byte(8'hAA, ak); chk(!ak, "R2 strap 010 mismatch", ak, 0); bus_stop;

    sda_m = 1'b1; tick(Q);
    send_byte(dev(0), ak); chk(!ak, "R1 no start no ack", ak, 0);
    bus_start;
    for (int i = 7; i >= 4; i--) begin
      sda_m = dev(0)[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
    bus_start; send_byte(dev(1), ak); chk(ak, "R1 restart after partial byte", ak, 1);
    recv_byte(b, 1'b0); bus_stop;
    chk(viol == 0, "R10 pull stable while SCL high", viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule